// File: doc/BRIEF.md
# Self-Recovering Modulo-6 Sequence Counter

This block is a 3-bit synchronous counter. On each rising clock edge it steps through six of its eight codes in the fixed order 000, 001, 010, 100, 101, 110, and then returns to 000. The codes 011 and 111 are not part of the cycle. The next-state logic still gives each of them a defined successor inside the cycle, so a state upset by noise or a bad power-up cannot leave the counter stuck. Each state bit is held in a JK-style flop. All three flops share the clock and update on the same edge.

The state bits are named from the most significant down: bit 2 is the high bit, bit 1 the middle bit and bit 0 the low bit. The excitation functions are as follows. The high bit toggles when the middle bit is 1. The middle bit is set from the low bit and is otherwise cleared. The low bit is set only when both the middle and low bits are 0.

A synchronous reset returns the counter to 000. A preset port loads any 3-bit code on the next edge, including the two unused codes, so that recovery can be forced and observed. There is no data stream, so every pin is a plain control or status pin and has no handshake.

Top module: `cnt6_selfheal`

## Requirements
- R1: With `rst` and `preset_en` both low, each rising edge moves `count_q` one step along 000→001→010→100→101→110→000.
- R2: With `rst` and `preset_en` low, code 011 is followed by 100 on the next rising edge.
- R3: With `rst` and `preset_en` low, code 111 is followed by 000 on the next rising edge.
- R4: `rst` high at a rising edge makes `count_q` 000 after that edge, and it overrides `preset_en`.
- R5: With `rst` low and `preset_en` high at a rising edge, `count_q` takes the value of `preset_code` after that edge, for all eight codes.
- R6: From any starting code, one advancing edge always produces a code other than 011 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all state bits |
| rst | input | 1 | Synchronous reset, active high, forces 000 |
| preset_en | input | 1 | Load `preset_code` on the next edge when high |
| preset_code | input | 3 | Code to load, any of the eight values |
| count_q | output | 3 | Current state, bit 2 is the most significant |

## Verification
The bench presets each of the eight codes in turn and advances one edge. This compares every successor against a modulo-6 index model, which separates faults in the in-cycle steps from faults in the two recovery paths. A free run of many cycles after reset checks the ordering and the wrap from 110 back to 000. Applying reset and preset together shows which of the two wins. Walks of several steps from each unused code confirm that the counter rejoins the cycle and stays in it.

// File: rtl/cnt6_pkg.sv
package cnt6_pkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] code_t;
  localparam int HI  = STATE_W - 1;
  localparam int MID = STATE_W - 2;
  localparam int LO  = 0;
  localparam code_t CODE_ZERO = '0;
endpackage

// File: rtl/cnt6_excite.sv
module cnt6_excite
  import cnt6_pkg::*;
(
  input  code_t cur,
  output code_t j_vec,
  output code_t k_vec
);
  always_comb begin
    // high bit: J = K = middle bit, so it toggles while the middle bit is set
    j_vec[HI]  = cur[MID];
    k_vec[HI]  = cur[MID];
    // middle bit: set from the low bit, always cleared otherwise
    j_vec[MID] = cur[LO];
    k_vec[MID] = 1'b1;
    // low bit: set only when the middle bit is clear, always cleared otherwise
    j_vec[LO]  = ~cur[MID];
    k_vec[LO]  = 1'b1;
  end
endmodule

// File: rtl/cnt6_jkbit.sv
module cnt6_jkbit (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_val,
  input  logic j,
  input  logic k,
  output logic q
);
  logic nxt;

  always_comb begin
    unique case ({j, k})
      2'b00:   nxt = q;
      2'b01:   nxt = 1'b0;
      2'b10:   nxt = 1'b1;
      default: nxt = ~q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= load_val;
    else           q <= nxt;
  end
endmodule

// File: rtl/cnt6_selfheal.sv
module cnt6_selfheal
  import cnt6_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               preset_en,
  input  logic [STATE_W-1:0] preset_code,
  output logic [STATE_W-1:0] count_q
);
  code_t j_vec, k_vec, state;

  cnt6_excite u_excite (
    .cur   (state),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar b = 0; b < STATE_W; b++) begin : g_bit
    cnt6_jkbit u_ff (
      .clk      (clk),
      .rst      (rst),
      .load     (preset_en),
      .load_val (preset_code[b]),
      .j        (j_vec[b]),
      .k        (k_vec[b]),
      .q        (state[b])
    );
  end

  assign count_q = state;
endmodule

// File: rtl/cnt6_selfheal_chk.sv
module cnt6_selfheal_chk
  import cnt6_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         preset_en,
  input logic [2:0]   preset_code,
  input logic [2:0]   count_q
);
  logic adv;
  assign adv = !rst && !preset_en;

  // R1: the step that crosses into the upper half, and the wrap
  p_cross_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && count_q == 3'b010) |=> count_q == 3'b100);
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && count_q == 3'b110) |=> count_q == 3'b000);
  // R2
  p_heal3_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && count_q == 3'b011) |=> count_q == 3'b100);
  // R3
  p_heal7_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && count_q == 3'b111) |=> count_q == 3'b000);
  // R5
  p_preset_r5: assert property (@(posedge clk) disable iff (rst)
    preset_en |=> count_q == $past(preset_code));
  // R6
  p_valid_r6: assert property (@(posedge clk) disable iff (rst)
    adv |=> (count_q != 3'b011 && count_q != 3'b111));
endmodule

bind cnt6_selfheal cnt6_selfheal_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .preset_en   (preset_en),
  .preset_code (preset_code),
  .count_q     (count_q)
);

// File: tb/sim_cnt6_selfheal.sv
module sim_cnt6_selfheal;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       preset_en = 1'b0;
  logic [2:0] preset_code = 3'b000;
  logic [2:0] count_q;
  int runs = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cnt6_selfheal u0 (
    .clk(clk), .rst(rst), .preset_en(preset_en),
    .preset_code(preset_code), .count_q(count_q)
  );

  // reference: map code to index 0..5 and back
  function automatic logic [2:0] ref_next(input logic [2:0] c);
    int idx;
    if (c == 3'd3) return 3'd4;
    if (c == 3'd7) return 3'd0;
    idx = int'(c) - int'(c[2]);
    idx = (idx + 1) % 6;
    return 3'(idx + (idx >= 3 ? 1 : 0));
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    runs++;
    if (count_q !== exp) begin
      fails++;
      $display("FAIL %s: count_q=%b expected %b", req, count_q, exp);
    end
  endtask

  task automatic edge_step(input logic r, input logic pe, input logic [2:0] pc);
    rst = r; preset_en = pe; preset_code = pc;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: count_q=%b expected completion", count_q);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [2:0] exp;
    @(negedge clk);
    edge_step(1'b1, 1'b0, 3'b000);
    check("R4 reset", 3'b000);

    // R1: free run through several full cycles
    exp = 3'b000;
    for (int n = 0; n < 30; n++) begin
      edge_step(1'b0, 1'b0, 3'b000);
      exp = ref_next(exp);
      check("R1 sequence", exp);
    end

    // R5 and successor of every code (R1, R2, R3, R6)
    for (int c = 0; c < 8; c++) begin
      edge_step(1'b0, 1'b1, 3'(c));
      check("R5 preset", 3'(c));
      edge_step(1'b0, 1'b0, 3'b000);
      if (c == 3)      check("R2 heal 011", 3'b100);
      else if (c == 7) check("R3 heal 111", 3'b000);
      else             check("R1 step", ref_next(3'(c)));
      runs++;
      if (count_q == 3'b011 || count_q == 3'b111) begin
        fails++;
        $display("FAIL R6: count_q=%b expected a cycle code", count_q);
      end
    end

    // R6: walk several steps after each unused code
    for (int u = 0; u < 2; u++) begin
      exp = (u == 0) ? 3'b011 : 3'b111;
      edge_step(1'b0, 1'b1, exp);
      for (int s = 0; s < 7; s++) begin
        edge_step(1'b0, 1'b0, 3'b000);
        exp = ref_next(exp);
        check("R6 walk", exp);
      end
    end

    // R4: reset wins over preset
    edge_step(1'b0, 1'b1, 3'b101);
    check("R5 preset 101", 3'b101);
    edge_step(1'b1, 1'b1, 3'b110);
    check("R4 reset over preset", 3'b000);
    edge_step(1'b1, 1'b0, 3'b000);
    check("R4 reset hold", 3'b000);
    edge_step(1'b0, 1'b0, 3'b000);
    check("R1 after reset", 3'b001);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule